// File: doc/BRIEF.md
# Spread-Spectrum Triangular Offset Generator

This block produces a signed frequency-offset word for the fractional feedback divider of a clock synthesizer. The word follows a triangular profile. Each period starts at the lowest frequency, climbs linearly to the highest, then falls back. The synthesized clock is therefore frequency-modulated, which spreads its energy and lowers the peak EMI. The offset is expressed in units of 0.001 % (parts per 100k) and is updated once per tick. Ticks are derived from the reference clock through a programmable terminal count. Each half period contains 64 ticks.

Two spread modes are supported. In center spread, the profile is symmetric about zero, so the average frequency equals the target. In down spread, the profile tops out at zero and all deviation is negative. A rate select chooses between two terminal counts. These are set so that the period lands near 31 kHz (for downstream PLLs or PCI) or near 120 kHz. Mode, deviation and rate are sampled only at the start of a period, so a reconfiguration never causes a step in the output. When modulation is disabled, the offset is forced to zero.

Top module: `ss_tri_mod`

## Requirements
- R1: While `rst_ni` is low, and after reset while `en_i` is low, `offset_o` is 0.
- R2: `en_i` low forces `offset_o` to 0 from the next clock edge. Counters restart, so the first value after `en_i` returns high is the profile minimum.
- R3: A tick occurs every T = tc+1 clocks. tc is `tc_fast_i` when `fast_i`=1 and `tc_slow_i` when `fast_i`=0. Counting edges from the first enabled edge as n=0, the value after edge n is P(floor(n/T) mod 128).
- R4: P(k) = low + floor(span*pos/64). Here pos = k for k ≤ 64 and pos = 128−k otherwise.
- R5: Center spread (`down_i`=0) with clamped deviation d: h = floor(d/2), low = −h, span = 2h. The profile therefore spans −h to +h.
- R6: Down spread (`down_i`=1) with clamped deviation d: low = −d and span = d. The maximum is therefore 0 and the minimum is −d.
- R7: In center spread, `dev_i` is clamped to the range 125..2000 (0.125 %..2.0 %).
- R8: In down spread, `dev_i` is clamped to the range 250..4000 (0.25 %..4.0 %).
- R9: While enabled, `down_i`, `dev_i`, `fast_i` and the terminal counts are sampled only at the edge that ends tick 127. Changes at any other time have no effect until the next period begins.
- R10: Within a period, P(k) = P(128−k) for 1 ≤ k ≤ 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Modulation enable; low gives a zero offset |
| down_i | input | 1 | 1 = down spread, 0 = center spread |
| dev_i | input | 16 | Total deviation, units of 0.001 % |
| fast_i | input | 1 | Rate select: 1 = fast terminal count |
| tc_slow_i | input | TCW | Tick terminal count for the slow rate |
| tc_fast_i | input | TCW | Tick terminal count for the fast rate |
| offset_o | output | 16 | Signed frequency offset, units of 0.001 % |

## Verification
The hardest condition to reach is a reconfiguration that arrives mid-period and must stay invisible until the minimum point. Changes that alter the tick length at the same moment are especially demanding. The stimulus therefore changes mode, deviation and rate partway through every period, then compares every clock of the following period against the arithmetic profile. The clamp limits are reached by feeding out-of-range deviations in both modes. Disabling in mid-ramp, then re-enabling, checks that the profile restarts at its minimum.

// File: rtl/ss_tri_pkg.sv
package ss_tri_pkg;
  localparam int DEV_W = 16;
  localparam int OFS_W = 16;
  localparam logic [DEV_W-1:0] CTR_MIN = 16'd125;
  localparam logic [DEV_W-1:0] CTR_MAX = 16'd2000;
  localparam logic [DEV_W-1:0] DN_MIN  = 16'd250;
  localparam logic [DEV_W-1:0] DN_MAX  = 16'd4000;

  function automatic logic [DEV_W-1:0] clamp_dev(input logic down, input logic [DEV_W-1:0] d);
    logic [DEV_W-1:0] lo, hi;
    lo = down ? DN_MIN : CTR_MIN;
    hi = down ? DN_MAX : CTR_MAX;
    if (d < lo)      return lo;
    else if (d > hi) return hi;
    else             return d;
  endfunction
endpackage

// File: rtl/ss_rate_div.sv
module ss_rate_div #(
  parameter int TCW = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [TCW-1:0] tc_i,
  output logic           tick_o
);
  logic [TCW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == tc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || tick_o)   cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ss_cfg_latch.sv
module ss_cfg_latch
  import ss_tri_pkg::*;
#(
  parameter int TCW = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic             down_i,
  input  logic [DEV_W-1:0] dev_i,
  input  logic             fast_i,
  input  logic [TCW-1:0]   tc_slow_i,
  input  logic [TCW-1:0]   tc_fast_i,
  output logic             mode_q_o,
  output logic [DEV_W-1:0] dev_q_o,
  output logic [TCW-1:0]   tc_q_o
);
  // track inputs while idle, sample only at period start while running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q_o <= 1'b0;
      dev_q_o  <= CTR_MIN;
      tc_q_o   <= '0;
    end else if (!en_i || load_i) begin
      mode_q_o <= down_i;
      dev_q_o  <= clamp_dev(down_i, dev_i);
      tc_q_o   <= fast_i ? tc_fast_i : tc_slow_i;
    end
  end
endmodule

// File: rtl/ss_profile.sv
module ss_profile
  import ss_tri_pkg::*;
#(
  parameter int HALF_LOG2 = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             mode_i,
  input  logic [DEV_W-1:0] dev_i,
  output logic             wrap_o,
  output logic [OFS_W-1:0] offset_o
);
  localparam int PH_W = HALF_LOG2 + 1;
  localparam int PW   = DEV_W + PH_W;
  localparam logic [PH_W-1:0] HALF = PH_W'(1) << HALF_LOG2;

  logic [PH_W-1:0]  ph_q;
  logic [PH_W-1:0]  pos;
  logic [DEV_W-1:0] span;
  logic [DEV_W-1:0] low_mag;
  logic [OFS_W-1:0] offset_d;

  assign wrap_o = tick_i && (ph_q == '1);

  always_comb begin
    pos     = (ph_q <= HALF) ? ph_q : PH_W'(-ph_q);
    span    = mode_i ? dev_i : {dev_i[DEV_W-1:1], 1'b0};
    low_mag = mode_i ? dev_i : (dev_i >> 1);
    if (en_i)
      offset_d = OFS_W'((PW'(span) * PW'(pos)) >> HALF_LOG2) - OFS_W'(low_mag);
    else
      offset_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= '0;
      offset_o <= '0;
    end else begin
      offset_o <= offset_d;
      if (!en_i)       ph_q <= '0;
      else if (tick_i) ph_q <= ph_q + 1'b1;
    end
  end
endmodule

// File: rtl/ss_tri_mod.sv
module ss_tri_mod
  import ss_tri_pkg::*;
#(
  parameter int TCW       = 12,
  parameter int HALF_LOG2 = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             down_i,
  input  logic [DEV_W-1:0] dev_i,
  input  logic             fast_i,
  input  logic [TCW-1:0]   tc_slow_i,
  input  logic [TCW-1:0]   tc_fast_i,
  output logic [OFS_W-1:0] offset_o
);
  logic             tick_w;
  logic             wrap_w;
  logic             mode_q;
  logic [DEV_W-1:0] dev_q;
  logic [TCW-1:0]   tc_q;

  ss_cfg_latch #(.TCW(TCW)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .load_i   (wrap_w),
    .down_i   (down_i),
    .dev_i    (dev_i),
    .fast_i   (fast_i),
    .tc_slow_i(tc_slow_i),
    .tc_fast_i(tc_fast_i),
    .mode_q_o (mode_q),
    .dev_q_o  (dev_q),
    .tc_q_o   (tc_q)
  );

  ss_rate_div #(.TCW(TCW)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (en_i),
    .tc_i  (tc_q),
    .tick_o(tick_w)
  );

  ss_profile #(.HALF_LOG2(HALF_LOG2)) u_prof (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .tick_i  (tick_w),
    .mode_i  (mode_q),
    .dev_i   (dev_q),
    .wrap_o  (wrap_w),
    .offset_o(offset_o)
  );
endmodule

// File: rtl/ss_tri_mod_chk.sv
module ss_tri_mod_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic        mode_q,
  input logic [15:0] dev_q,
  input logic        tick_w,
  input logic [15:0] offset_o
);
  AST_DIS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (offset_o == 16'd0)); // R2

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && $past(en_i, 2) && !$past(tick_w, 2)) |-> $stable(offset_o)); // R3

  AST_CENTER_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && !$past(mode_q)) |->
      ($signed(offset_o) >= -16'sd1000 && $signed(offset_o) <= 16'sd1000)); // R5

  AST_DOWN_NONPOS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && $past(mode_q)) |->
      ($signed(offset_o) <= 16'sd0 && $signed(offset_o) >= -16'sd4000)); // R6

  AST_CENTER_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q |-> (dev_q >= 16'd125 && dev_q <= 16'd2000)); // R7

  AST_DOWN_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |-> (dev_q >= 16'd250 && dev_q <= 16'd4000)); // R8
endmodule

bind ss_tri_mod ss_tri_mod_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .mode_q  (mode_q),
  .dev_q   (dev_q),
  .tick_w  (tick_w),
  .offset_o(offset_o)
);

// File: tb/ss_tri_mod_bench.sv
module ss_tri_mod_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        down = 1'b0;
  logic [15:0] dev = 16'd1000;
  logic        fast = 1'b1;
  logic [11:0] tc_slow = 12'd3;
  logic [11:0] tc_fast = 12'd0;
  logic [15:0] offset;

  int total = 0;
  int bad = 0;
  int prof [0:127];

  always #5 clk = ~clk;

  ss_tri_mod u_ss_tri_mod (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .en_i     (en),
    .down_i   (down),
    .dev_i    (dev),
    .fast_i   (fast),
    .tc_slow_i(tc_slow),
    .tc_fast_i(tc_fast),
    .offset_o (offset)
  );

  function automatic int exp_off(bit dn, int d, int k);
    int pos;
    int h;
    pos = (k <= 64) ? k : 128 - k;
    if (dn) return -d + (d * pos) / 64;
    h = d / 2;
    return -h + (2 * h * pos) / 64;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // checks one whole period; applies next config at tick 40, optional disable at stop_k
  task automatic run_period(bit dn, int d, int t, string clamp_req,
                            bit n_dn, int n_dev, bit n_fast, int stop_k);
    string req;
    for (int k = 0; k < 128; k++) begin
      for (int j = 0; j < t; j++) begin
        @(posedge clk); #2;
        if (j > 0)       req = "R3";
        else if (k > 40) req = "R9";
        else             req = "R4";
        check(req, int'($signed(offset)), exp_off(dn, d, k));
        if (j == 0) prof[k] = int'($signed(offset));
        if (k == 40 && j == 0) begin
          down = n_dn; dev = n_dev[15:0]; fast = n_fast;
        end
        if (k == stop_k && j == 0) begin
          en = 1'b0;
          return;
        end
      end
    end
    if (dn) begin
      check("R6", prof[64], 0);
      check(clamp_req, prof[0], -d);
    end else begin
      check("R5", prof[64], d / 2);
      check(clamp_req, prof[0], -(d / 2));
    end
    for (int k = 1; k < 64; k++) check("R10", prof[k], prof[128 - k]);
  endtask

  initial begin
    #35; check("R1", int'(offset), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", int'(offset), 0);
    down = 1'b0; dev = 16'd1000; fast = 1'b1;
    @(negedge clk); en = 1'b1;
    run_period(1'b0, 1000, 1, "R5", 1'b0, 50,   1'b1, -1);
    run_period(1'b0, 125,  1, "R7", 1'b0, 9000, 1'b0, -1);
    run_period(1'b0, 2000, 4, "R7", 1'b1, 100,  1'b1, -1);
    run_period(1'b1, 250,  1, "R8", 1'b1, 5000, 1'b1, -1);
    run_period(1'b1, 4000, 1, "R8", 1'b1, 3333, 1'b0, -1);
    run_period(1'b1, 3333, 4, "R6", 1'b0, 1001, 1'b1, -1);
    run_period(1'b0, 1001, 1, "R5", 1'b0, 1001, 1'b1, 30);
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #2;
      check("R2", int'(offset), 0);
      if (i == 5) begin down = 1'b1; dev = 16'd2000; fast = 1'b1; end
    end
    en = 1'b1;
    run_period(1'b1, 2000, 1, "R2", 1'b1, 2000, 1'b1, -1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule